// File: doc/BRIEF.md
# Fused Two-Phase Handshake Checker

This block watches a transfer made of two phases and reports, for every attempt, whether the transfer followed the expected cycle timing. An attempt opens when `valid_i` is high at a rising clock edge. In the next cycle the address phase must finish with `addr_done_i`. The data phase is `data_valid_i` followed one cycle later by `data_done_i`.

The `GAP` parameter sets how the two phases join. With `GAP = 0` the phases are fused: the cycle that closes the address phase is also the cycle that opens the data phase, so `addr_done_i` and `data_valid_i` are both needed in that one cycle. With `GAP = 1` the data phase opens one cycle after the address phase closes, and every later check moves one cycle later.

A new attempt may open on any cycle. Every attempt in flight is checked on its own. The outputs are combinational pulses raised during the cycle in which the deciding input is sampled.

Top module: `hs_fused_chk`

## Requirements
- R1: An attempt opens only when `valid_i` is sampled high. While no attempt is in flight, `match_o` and `mismatch_o` stay low whatever the done and data lines do.
- R2: For an attempt opened at cycle T, `addr_done_i` must be high at T+1. If it is low, `mismatch_o` is high in cycle T+1.
- R3: With `GAP = 0`, `data_valid_i` must also be high at T+1, so the join is passed only when `addr_done_i` and `data_valid_i` are both high in that cycle. `data_done_i` must then be high at T+2, and `match_o` is high in cycle T+2.
- R4: With `GAP = 1`, `data_valid_i` is required at T+2 and `data_done_i` at T+3. `match_o` is high in cycle T+3, one cycle later than with `GAP = 0`.
- R5: When a required input is low at its scheduled cycle, that attempt raises `mismatch_o` for that one cycle and is then dropped. It produces no later match and no later mismatch.
- R6: Attempts may open on consecutive cycles and are tracked independently. When several attempts decide in the same cycle, the two outputs are the OR over those attempts.
- R7: Asserting `rst_ni` low drops every attempt in flight. No match or mismatch is raised while reset is asserted, and no in-flight attempt raises one after reset is released.
- R8: `GAP` accepts only 0 or 1. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all checks use the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Opens an attempt when sampled high |
| addr_done_i | input | 1 | End of the address phase |
| data_valid_i | input | 1 | Start of the data phase |
| data_done_i | input | 1 | End of the data phase |
| match_o | output | 1 | High in the cycle an attempt completes correctly |
| mismatch_o | output | 1 | High in the cycle one or more attempts fail |

## Verification
The bench runs one stream of inputs through a `GAP = 0` instance and a `GAP = 1` instance side by side. This means an off-by-one join shows up as a match in the wrong cycle, or as a mismatch where the other instance passes.

The stream covers several cases:
- A join cycle where `data_valid_i` is high but `addr_done_i` is low, and the reverse. A checker that tested only one of the two lines at the fused cycle would miss one of these failures.
- Done lines toggling with nothing in flight. This catches a checker that does not gate its outputs on an open attempt.
- Three attempts opened back to back that fail together. This catches a checker that loses overlapping attempts or stops after the first failure.
- A reset applied while an attempt is in flight. A checker that kept that attempt would raise a match after reset is released.

// File: rtl/hs_chk_pkg.sv
package hs_chk_pkg;

  typedef struct packed {
    logic addr_done;
    logic data_valid;
    logic data_done;
  } hs_in_t;

  // condition an attempt must meet AGE cycles after it opened
  function automatic logic age_ok(int unsigned gap, int unsigned age, hs_in_t x);
    logic ok;
    if (gap == 0) begin
      ok = (age == 1) ? (x.addr_done & x.data_valid) : x.data_done;
    end else begin
      case (age)
        1:       ok = x.addr_done;
        2:       ok = x.data_valid;
        default: ok = x.data_done;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/hs_age_req.sv
module hs_age_req
  import hs_chk_pkg::*;
#(
  parameter int unsigned GAP = 0,
  parameter int unsigned AGE = 1
) (
  input  hs_in_t in_i,
  output logic   ok_o
);

  always_comb ok_o = age_ok(GAP, AGE, in_i);

endmodule

// File: rtl/hs_age_stage.sv
module hs_age_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alive_i,
  input  logic ok_i,
  output logic pass_o,
  output logic fail_o
);

  logic alive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alive_q <= 1'b0;
    else         alive_q <= alive_i;
  end

  assign pass_o = alive_q & ok_i;
  assign fail_o = alive_q & ~ok_i;

endmodule

// File: rtl/hs_fused_chk.sv
module hs_fused_chk
  import hs_chk_pkg::*;
#(
  parameter int unsigned GAP = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic addr_done_i,
  input  logic data_valid_i,
  input  logic data_done_i,
  output logic match_o,
  output logic mismatch_o
);

  localparam int unsigned LAST = 2 + GAP;  // age at which data_done is due

  generate
    if (GAP > 1) begin : g_bad_gap
      initial $fatal(1, "hs_fused_chk: GAP must be 0 or 1 (R8)");
    end
  endgenerate

  hs_in_t            cur;
  logic [LAST:1]     stg_in;
  logic [LAST:1]     stg_ok;
  logic [LAST:1]     stg_pass;
  logic [LAST:1]     stg_fail;

  assign cur = '{addr_done: addr_done_i, data_valid: data_valid_i, data_done: data_done_i};
  assign stg_in[1] = valid_i;

  for (genvar k = 1; k <= LAST; k++) begin : g_age
    if (k > 1) begin : g_chain
      assign stg_in[k] = stg_pass[k-1];
    end
    hs_age_req #(.GAP(GAP), .AGE(k)) u_req (
      .in_i (cur),
      .ok_o (stg_ok[k])
    );
    hs_age_stage u_stg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alive_i (stg_in[k]),
      .ok_i    (stg_ok[k]),
      .pass_o  (stg_pass[k]),
      .fail_o  (stg_fail[k])
    );
  end

  assign match_o    = stg_pass[LAST];
  assign mismatch_o = |stg_fail;

  // R2: a captured attempt with addr_done missing one cycle later must fail
  a_r2_addr_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(valid_i) && !addr_done_i) |-> mismatch_o);

  // R1: a match traces back to a valid sampled LAST cycles earlier
  a_r1_match_has_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(valid_i, LAST));

  // R3/R4: a match needs data_done in the same cycle
  a_r3_done_at_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> data_done_i);

  generate
    if (GAP == 0) begin : g_fused_chk
      // R3: fused join needs both lines in one cycle
      a_r3_fused_join: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> $past(addr_done_i && data_valid_i));
    end else begin : g_gap_chk
      // R4: data_valid one cycle before data_done
      a_r4_gap_join: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> ($past(data_valid_i) && $past(addr_done_i, 2)));
    end
  endgenerate

  // R7: the cycle after a reset edge is quiet
  a_r7_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (!match_o && !mismatch_o));

endmodule

// File: tb/hs_fused_chk_tb.sv
`timescale 1ns/1ps
module hs_fused_chk_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid, addr_done, data_valid, data_done;
  logic m0, x0, m1, x1;
  int   total = 0;
  int   bad = 0;
  bit   finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  hs_fused_chk #(.GAP(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .addr_done_i(addr_done),
    .data_valid_i(data_valid), .data_done_i(data_done),
    .match_o(m0), .mismatch_o(x0));

  hs_fused_chk #(.GAP(1)) u_dut_gap1 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .addr_done_i(addr_done),
    .data_valid_i(data_valid), .data_done_i(data_done),
    .match_o(m1), .mismatch_o(x1));

  // {valid, addr_done, data_valid, data_done, m0, x0, m1, x1}
  localparam int NV = 19;
  localparam logic [7:0] VEC [NV] = '{
    8'b1000_0000,  // 0  open
    8'b0110_0000,  // 1  join ok for both
    8'b0011_1000,  // 2  R3 match gap0
    8'b0001_0010,  // 3  R4 match gap1; R1 done high, nothing open in gap0
    8'b0000_0000,  // 4
    8'b1000_0000,  // 5  open
    8'b0100_0100,  // 6  R3 addr ok, data_valid low -> gap0 fails
    8'b0010_0000,  // 7  R5 gap0 attempt dropped
    8'b0001_0010,  // 8  R4 gap1 match
    8'b1000_0000,  // 9  open
    8'b1010_0101,  // 10 R2 addr_done low -> both fail; open again
    8'b0110_0000,  // 11
    8'b0001_1001,  // 12 gap0 match, gap1 data_valid missing
    8'b1111_0000,  // 13 R6 back-to-back opens
    8'b1111_0000,  // 14
    8'b1111_1000,  // 15
    8'b0000_0101,  // 16 R6 several fail together
    8'b0000_0000,  // 17 R5 nothing left
    8'b0000_0000   // 18
  };

  task automatic check(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%0b exp=%0b", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {valid, addr_done, data_valid, data_done} = v;
  endtask

  initial begin
    drive(4'b0000);
    #35;
    check(m0, 1'b0, "R7", "reset match gap0");
    check(x0, 1'b0, "R7", "reset mismatch gap0");
    check(m1, 1'b0, "R7", "reset match gap1");
    check(x1, 1'b0, "R7", "reset mismatch gap1");
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][7:4]);
      #8;
      check(m0, VEC[i][3], "R3 R6", $sformatf("row %0d match gap0", i));
      check(x0, VEC[i][2], "R2 R5", $sformatf("row %0d mismatch gap0", i));
      check(m1, VEC[i][1], "R4 R6", $sformatf("row %0d match gap1", i));
      check(x1, VEC[i][0], "R2 R5", $sformatf("row %0d mismatch gap1", i));
    end

    // R1: done/data lines busy with nothing open
    @(negedge clk);
    drive(4'b0111);
    #8;
    check(m0 | x0, 1'b0, "R1", "idle lines gap0");
    check(m1 | x1, 1'b0, "R1", "idle lines gap1");

    // R7: reset while an attempt is in flight
    @(negedge clk);
    drive(4'b1000);
    @(negedge clk);
    drive(4'b0110);
    #5;
    rst_ni = 1'b0;
    #3;
    check(m0 | x0, 1'b0, "R7", "during reset gap0");
    check(m1 | x1, 1'b0, "R7", "during reset gap1");
    @(negedge clk);
    drive(4'b0111);
    rst_ni = 1'b1;
    #8;
    check(m0 | x0, 1'b0, "R7", "after release gap0");
    check(m1 | x1, 1'b0, "R7", "after release gap1");
    @(negedge clk);
    drive(4'b0011);
    #8;
    check(m0 | x0, 1'b0, "R7", "second cycle after release gap0");
    check(m1 | x1, 1'b0, "R7", "second cycle after release gap1");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule